// File: doc/BRIEF.md
# Programmable AND-OR Logic Plane

This block is the logic core of a small programmable logic device. It takes twelve dedicated input signals and ten feedback signals and builds the true and inverted form of each one. The result is 44 array lines. Each product term is the AND of the lines whose connection bit is set, and the connection bits live in a configuration store inside the block. Fixed OR gates merge blocks of product terms into ten sum outputs. The blocks have unequal sizes, and the pattern of sizes is mirrored about the centre. Thirteen more product terms are brought out on their own: one enable term for each output, a global preset term, a global clear term and a clock term. The macrocells around the block use these signals.

The configuration is written one product term at a time. The write port takes an address and a 44-bit connection word, qualified by a write strobe. A single-cycle erase command opens every connection. A term with no connections reads as 1. Because of this, an erased or freshly reset plane drives every output high. A term that connects both polarities of the same signal reads as 0, and so it contributes nothing to its OR gate.

Top module: `pla_sop_array`

## Requirements
- R1: Array line 2*s carries signal s true and line 2*s+1 carries it inverted. Signals 0 to 11 are `in_i[0..11]` and signals 12 to 21 are `fb_i[0..9]`. Bit j of a connection word connects line j.
- R2: A product term is the AND of the lines whose connection bit is 1. A term with no bits set evaluates to 1.
- R3: A term that has both the true and the inverted line of one signal connected evaluates to 0 for every input.
- R4: Term addresses 0 to 119 feed the sum outputs in consecutive blocks. Starting from output 0, the block sizes are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8.
- R5: `sum_o[k]` is the OR of the terms in block k.
- R6: Address 120+k drives `oe_o[k]`. Address 130 drives `preset_o`, 131 drives `clear_o` and 132 drives `clk_term_o`.
- R7: When `cfg_we` is high at a rising clock edge, `cfg_data` is stored for term `cfg_addr`. The outputs reflect the new word from that edge on.
- R8: When `cfg_erase` is high at a rising edge, every connection bit is cleared in that one cycle. Erase wins over a write in the same cycle.
- R9: While reset is asserted, and after it, all connection bits are clear, so every output is 1.
- R10: A write to an address of 133 or above changes no stored term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low synchronous reset, clears the store |
| in_i | input | 12 | Dedicated input signals |
| fb_i | input | 10 | Feedback signals from the output cells |
| cfg_we | input | 1 | Write strobe for one term |
| cfg_addr | input | 8 | Term address, 0 to 132 |
| cfg_data | input | 44 | Connection word, bit j = line j |
| cfg_erase | input | 1 | Clear all connections |
| sum_o | output | 10 | OR of each term block |
| oe_o | output | 10 | Per-output enable terms |
| preset_o | output | 1 | Global preset term |
| clear_o | output | 1 | Global clear term |
| clk_term_o | output | 1 | Clock product term |

## Verification
The assertions assume that `cfg_we`, `cfg_erase`, `cfg_addr` and `cfg_data` are stable and known around each rising edge. They also assume that the array inputs settle before the outputs are sampled. Some properties look one cycle past a write to a control or enable term, so they also assume that `in_i` and `fb_i` do not affect the checked output in ways outside the written pattern. The bench meets these assumptions by changing all stimulus only on falling edges. It compares the outputs a short delay later, well before the next rising edge.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Number of product terms in OR block k.
    // The sizes grow toward the centre and then shrink again.
    function automatic int grp_size(input int k, input int n_out,
                                    input int base, input int step);
        int mirror;
        mirror = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
        return base + step * mirror;
    endfunction

    // First term address of OR block k.
    function automatic int grp_first(input int k, input int n_out,
                                     input int base, input int step);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += grp_size(j, n_out, base, step);
        end
        return acc;
    endfunction

    // Control terms that follow the enable terms, in address order.
    typedef enum logic [1:0] {
        CTL_PRESET = 2'd0,
        CTL_CLEAR  = 2'd1,
        CTL_CLOCK  = 2'd2
    } ctl_term_e;

    localparam int N_CTL = 3;

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int N_TERMS = 133,
    parameter int N_LINES = 44,
    parameter int ADDR_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [N_LINES-1:0]                data,
    input  logic                              erase,
    output logic [N_TERMS-1:0][N_LINES-1:0]   conn
);

    typedef struct packed {
        logic [N_TERMS-1:0][N_LINES-1:0] conn;
    } store_t;

    store_t st_d, st_q;
    logic   addr_ok;

    assign addr_ok = (int'(addr) < N_TERMS);

    always_comb begin
        st_d = st_q;
        if (erase) begin
            st_d.conn = '0;
        end else if (we && addr_ok) begin
            for (int t = 0; t < N_TERMS; t++) begin
                if (int'(addr) == t) begin
                    st_d.conn[t] = data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conn = st_q.conn;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_TERMS = 133,
    parameter int N_LINES = 44
) (
    input  logic [N_LINES-1:0]                lines,
    input  logic [N_TERMS-1:0][N_LINES-1:0]   conn,
    output logic [N_TERMS-1:0]                term
);

    // An open connection lets its line through as a 1.
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign term[t] = &(~conn[t] | lines);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int N_OUT     = 10,
    parameter int GRP_BASE  = 8,
    parameter int GRP_STEP  = 2,
    parameter int N_SOP     = 120
) (
    input  logic [N_SOP-1:0] term,
    output logic [N_OUT-1:0] sum
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_grp
        localparam int FIRST = grp_first(k, N_OUT, GRP_BASE, GRP_STEP);
        localparam int SIZE  = grp_size(k, N_OUT, GRP_BASE, GRP_STEP);
        assign sum[k] = |term[FIRST+SIZE-1:FIRST];
    end

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array
    import pla_pkg::*;
#(
    parameter int N_IN     = 12,
    parameter int N_FB     = 10,
    parameter int GRP_BASE = 8,
    parameter int GRP_STEP = 2,
    localparam int N_LINES = 2 * (N_IN + N_FB),
    localparam int N_SOP   = grp_first(N_FB, N_FB, GRP_BASE, GRP_STEP),
    localparam int N_TERMS = N_SOP + N_FB + N_CTL,
    localparam int ADDR_W  = $clog2(N_TERMS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IN-1:0]    in_i,
    input  logic [N_FB-1:0]    fb_i,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [N_LINES-1:0] cfg_data,
    input  logic               cfg_erase,
    output logic [N_FB-1:0]    sum_o,
    output logic [N_FB-1:0]    oe_o,
    output logic               preset_o,
    output logic               clear_o,
    output logic               clk_term_o
);

    localparam int N_SIG   = N_IN + N_FB;
    localparam int OE_BASE = N_SOP;
    localparam int CT_BASE = N_SOP + N_FB;

    logic [N_SIG-1:0]                 sig;
    logic [N_LINES-1:0]               lines;
    logic [N_TERMS-1:0][N_LINES-1:0]  conn;
    logic [N_TERMS-1:0]               term;

    assign sig = {fb_i, in_i};

    for (genvar s = 0; s < N_SIG; s++) begin : g_line
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end

    pla_cfg_store #(
        .N_TERMS (N_TERMS),
        .N_LINES (N_LINES),
        .ADDR_W  (ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .data  (cfg_data),
        .erase (cfg_erase),
        .conn  (conn)
    );

    pla_and_plane #(
        .N_TERMS (N_TERMS),
        .N_LINES (N_LINES)
    ) u_and (
        .lines (lines),
        .conn  (conn),
        .term  (term)
    );

    pla_or_plane #(
        .N_OUT    (N_FB),
        .GRP_BASE (GRP_BASE),
        .GRP_STEP (GRP_STEP),
        .N_SOP    (N_SOP)
    ) u_or (
        .term (term[N_SOP-1:0]),
        .sum  (sum_o)
    );

    assign oe_o       = term[OE_BASE +: N_FB];
    assign preset_o   = term[CT_BASE + int'(CTL_PRESET)];
    assign clear_o    = term[CT_BASE + int'(CTL_CLEAR)];
    assign clk_term_o = term[CT_BASE + int'(CTL_CLOCK)];

endmodule

// File: rtl/pla_sop_array_chk.sv
module pla_sop_array_chk
    import pla_pkg::*;
#(
    parameter int N_IN     = 12,
    parameter int N_FB     = 10,
    parameter int GRP_BASE = 8,
    parameter int GRP_STEP = 2,
    localparam int N_LINES = 2 * (N_IN + N_FB),
    localparam int N_SOP   = grp_first(N_FB, N_FB, GRP_BASE, GRP_STEP),
    localparam int N_TERMS = N_SOP + N_FB + N_CTL,
    localparam int ADDR_W  = $clog2(N_TERMS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_IN-1:0]    in_i,
    input logic [N_FB-1:0]    fb_i,
    input logic               cfg_we,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [N_LINES-1:0] cfg_data,
    input logic               cfg_erase,
    input logic [N_FB-1:0]    sum_o,
    input logic [N_FB-1:0]    oe_o,
    input logic               preset_o,
    input logic               clear_o,
    input logic               clk_term_o
);

    localparam int PRESET_A = N_SOP + N_FB + int'(CTL_PRESET);
    localparam int CLEAR_A  = N_SOP + N_FB + int'(CTL_CLEAR);

    logic all_high;
    assign all_high = (&sum_o) && (&oe_o) && preset_o && clear_o && clk_term_o;

    // R8: after an erase every term is empty, so every output is high.
    assert_erase_all_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> all_high);

    // R9: the first cycle out of reset shows an empty plane.
    assert_reset_all_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> all_high);

    // R2, R7: a preset term that connects only line 0 follows in_i[0].
    assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_erase && cfg_addr == ADDR_W'(PRESET_A)
         && cfg_data == N_LINES'(1))
        |=> (preset_o == in_i[0]));

    // R2: writing an empty word to the clear term makes it read high.
    assert_empty_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_erase && cfg_addr == ADDR_W'(CLEAR_A) && cfg_data == '0)
        |=> clear_o);

    // R3: both polarities of signal 0 on an enable term force it low.
    for (genvar k = 0; k < N_FB; k++) begin : g_oe
        assert_conflict_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_erase && cfg_addr == ADDR_W'(N_SOP + k)
             && cfg_data[1:0] == 2'b11)
            |=> !oe_o[k]);
    end

endmodule

bind pla_sop_array pla_sop_array_chk #(
    .N_IN     (N_IN),
    .N_FB     (N_FB),
    .GRP_BASE (GRP_BASE),
    .GRP_STEP (GRP_STEP)
) u_chk (.*);

// File: tb/pla_sop_array_tb.sv
module pla_sop_array_tb;

    localparam int NT = 133;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] in_i;
    logic [9:0]  fb_i;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [43:0] cfg_data;
    logic        cfg_erase;
    logic [9:0]  sum_o;
    logic [9:0]  oe_o;
    logic        preset_o, clear_o, clk_term_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [43:0] model [NT];
    int          gsz   [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    always #4 clk = ~clk;

    pla_sop_array u_dut (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .fb_i(fb_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_erase(cfg_erase), .sum_o(sum_o), .oe_o(oe_o),
        .preset_o(preset_o), .clear_o(clear_o), .clk_term_o(clk_term_o)
    );

    function automatic logic [43:0] mk_lines(logic [11:0] a, logic [9:0] f);
        logic [21:0] s;
        logic [43:0] l;
        s = {f, a};
        for (int i = 0; i < 22; i++) begin
            l[2*i]   = s[i];
            l[2*i+1] = ~s[i];
        end
        return l;
    endfunction

    function automatic logic eval_t(int t, logic [43:0] l);
        return &(~model[t] | l);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        logic [43:0] l;
        logic [9:0]  es, eo;
        int          b;
        l = mk_lines(in_i, fb_i);
        b = 0;
        for (int k = 0; k < 10; k++) begin
            es[k] = 1'b0;
            for (int j = 0; j < gsz[k]; j++) es[k] |= eval_t(b + j, l);
            b += gsz[k];
            eo[k] = eval_t(120 + k, l);
        end
        chk({req, " sum"}, 32'(sum_o), 32'(es));
        chk({req, " oe"}, 32'(oe_o), 32'(eo));
        chk({req, " ctl"}, 32'({clk_term_o, clear_o, preset_o}),
            32'({eval_t(132, l), eval_t(131, l), eval_t(130, l)}));
    endtask

    task automatic apply(logic [11:0] a, logic [9:0] f, string req);
        @(negedge clk);
        in_i = a;
        fb_i = f;
        #2;
        compare_all(req);
    endtask

    task automatic wr(logic [7:0] a, logic [43:0] d, logic er);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d; cfg_erase = er;
        @(negedge clk);
        cfg_we = 1'b0; cfg_erase = 1'b0;
        if (er) begin
            for (int t = 0; t < NT; t++) model[t] = '0;
        end else if (a < NT) begin
            model[a] = d;
        end
    endtask

    task automatic erase_all();
        @(negedge clk);
        cfg_erase = 1'b1;
        @(negedge clk);
        cfg_erase = 1'b0;
        for (int t = 0; t < NT; t++) model[t] = '0;
    endtask

    task automatic rand_fill();
        logic [43:0] d;
        for (int t = 0; t < NT; t++) begin
            d = '0;
            for (int r = 0; r < 3; r++) d[$urandom_range(0, 43)] = 1'b1;
            wr(8'(t), d, 1'b0);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int t = 0; t < NT; t++) model[t] = '0;
        rst_n = 1'b0; in_i = '0; fb_i = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; cfg_erase = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        // R9: plane is empty under reset
        chk("R9 reset", 32'({sum_o, oe_o, preset_o, clear_o, clk_term_o}), 32'h7FFFFF);
        rst_n = 1'b1;
        apply(12'hA5C, 10'h2B3, "R9 after reset");
        // R1: preset term on line 2*14+1 = fb_i[2] inverted
        wr(8'd130, 44'd1 << 29, 1'b0);
        apply('0, 10'h004, "R1 fb inverted");
        chk("R1 fb inverted low", 32'(preset_o), 32'd0);
        apply('0, 10'h000, "R1 fb inverted");
        chk("R1 fb inverted high", 32'(preset_o), 32'd1);
        // R1: clock term on line 22 = in_i[11] true
        wr(8'd132, 44'd1 << 22, 1'b0);
        apply(12'h800, '0, "R1 in true");
        chk("R1 in true", 32'(clk_term_o), 32'd1);
        // R3: both polarities of in_i[3] on oe term 4 and on term 0
        wr(8'd124, 44'b11 << 6, 1'b0);
        wr(8'd0, 44'b11 << 6, 1'b0);
        apply(12'h008, '0, "R3 conflict");
        chk("R3 conflict", 32'(oe_o[4]), 32'd0);
        apply(12'h000, '0, "R3 conflict");
        // R2: empty term written back reads high
        wr(8'd124, '0, 1'b0);
        apply(12'h3C3, 10'h155, "R2 empty");
        chk("R2 empty", 32'(oe_o[4]), 32'd1);
        // R8: erase clears everything
        rand_fill();
        erase_all();
        apply(12'h001, 10'h001, "R8 erase");
        // R8: erase wins over a same-cycle write
        wr(8'd131, 44'b11, 1'b1);
        apply('0, '0, "R8 erase priority");
        chk("R8 erase priority", 32'(clear_o), 32'd1);
        // R10: out-of-range addresses change nothing
        wr(8'd133, 44'b11, 1'b0);
        wr(8'd255, 44'b11, 1'b0);
        wr(8'd200, 44'b11, 1'b0);
        apply(12'h0F0, 10'h0F0, "R10 out of range");
        chk("R10 out of range", 32'({sum_o, oe_o, preset_o, clear_o, clk_term_o}),
            32'h7FFFFF);
        // R4, R5, R6, R7: random patterns against the model
        for (int p = 0; p < 4; p++) begin
            rand_fill();
            for (int v = 0; v < 150; v++) begin
                apply(12'($urandom), 10'($urandom), "R4 R5 R6 R7 random");
            end
        end
        // R4: last term of each block alone drives its sum
        erase_all();
        begin
            int b = 0;
            for (int k = 0; k < 10; k++) begin
                for (int j = 0; j < gsz[k]; j++) wr(8'(b + j), 44'b11, 1'b0);
                wr(8'(b + gsz[k] - 1), 44'd1 << (2 * k), 1'b0);
                b += gsz[k];
            end
        end
        apply(12'h2AA, '0, "R4 block edges");
        chk("R4 block edges", 32'(sum_o), 32'h2AA);
        apply(12'h155, '0, "R4 block edges");
        chk("R4 block edges", 32'(sum_o), 32'h155);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule